// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vectorised load or store command into a stream of per-element effective addresses. A command is captured from a set of plain configuration pins when `start` is high while the block is idle. It then walks element numbers 0 to VL-1. It reads the base and index operands through two combinational read selects. Predicated-off elements are dropped. For every remaining element it offers the address, the base-update value and the source, destination and update register element numbers on a valid/ready stream.

The addressing mode comes from the form bit (immediate or register-indexed), the stride-select bit and the vector/scalar flags of the operands. The immediate forms cover unit stride, element stride, splat, vector base plus immediate, and post-increment. The register-indexed forms cover plain indexed addressing and a register-strided variant. The index operand can be sign- or zero-extended from a narrow source width. All arithmetic is 64-bit and wraps.

Back-pressure rules: once `el_valid` is high it stays high, with every `el_*` field unchanged, until a rising clock edge sees `el_ready` high. `el_valid` never depends on `el_ready`. The read-data inputs must follow the read selects combinationally and must be held unchanged for the whole command.

Top module: `vlsu_agen`

## Requirements
- R1: After reset, `busy`, `done` and `el_valid` are low.
- R2: `start` is taken only while `busy` is low, and all `cfg_*` pins are captured at that edge. A `start` while busy has no effect. A presented element holds `el_valid` and all `el_*` fields until it is accepted with `el_ready`.
- R3: Unit stride applies to the immediate form with a scalar base, no post-increment and `cfg_els`=0. Element e gets base + imm + e*2^`cfg_op_size`, with `cfg_op_size` 0..3 meaning 1, 2, 4 or 8 bytes.
- R4: Element stride applies to the immediate form with a scalar base, no post-increment, `cfg_els`=1 and a nonzero imm. Element e gets base + e*imm.
- R5: Splat applies to the immediate form with a scalar base, no post-increment, `cfg_els`=1 and imm=0. Every element gets base + imm.
- R6: Vector base applies to the immediate form with a vector base and no post-increment. Element e gets base[e] + imm, and `cfg_els` has no effect.
- R7: Post-increment applies to the immediate form with `cfg_post_inc`=1. The address is the base value (base[e] for a vector base, else base[0]), and `el_upd_val` is that base + imm. In every other mode `el_upd_val` equals `el_addr`.
- R8: The register-indexed form addresses base[i] + X(index[k]) unless R9 applies. Here i = e for a vector base, else 0, and k = e for a vector index, else 0.
- R9: The register-indexed form with scalar base, scalar index and `cfg_els`=1 addresses base + X(index)*j, where j = e for a vector destination, else 0.
- R10: X() extends the index from `cfg_src_ew` (0: 8, 1: 16, 2: 32, 3: full 64 bits). It sign-extends when `cfg_sea`=1 and zero-extends otherwise.
- R11: An element whose `cfg_pred` bit is 0 is not presented when any operand in use (base, destination, update, or index in the indexed form) is a vector. Each skip costs one cycle. `el_src`, `el_dst` and `el_upd` are e for a vector operand and 0 for a scalar one.
- R12: With a scalar destination the command ends after its first presented element.
- R13: `done` is high for exactly one cycle, the cycle after the last element is accepted or skipped, and `busy` falls at the next edge. VL=0 gives `done` with no elements. VL above MAXVL counts as MAXVL.
- R14: All address sums and products wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture a command when idle |
| cfg_indexed | input | 1 | 1: register-indexed form, 0: immediate form |
| cfg_base_vec | input | 1 | Base operand is a vector |
| cfg_idx_vec | input | 1 | Index operand is a vector |
| cfg_dst_vec | input | 1 | Destination is a vector |
| cfg_upd_vec | input | 1 | Update register is a vector |
| cfg_els | input | 1 | Stride select |
| cfg_post_inc | input | 1 | Post-increment (immediate form) |
| cfg_sea | input | 1 | Sign-extend the index |
| cfg_op_size | input | 2 | log2 of access bytes |
| cfg_src_ew | input | 2 | Index source width code |
| cfg_imm | input | XLEN | Immediate, already 64-bit |
| cfg_vl | input | VLW | Vector length |
| cfg_pred | input | MAXVL | Source predicate mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| base_sel | output | IW | Base operand element select |
| base_data | input | XLEN | Base operand at `base_sel` |
| idx_sel | output | IW | Index operand element select |
| idx_data | input | XLEN | Index operand at `idx_sel` |
| el_valid | output | 1 | Element offered |
| el_ready | input | 1 | Element taken |
| el_addr | output | XLEN | Effective address |
| el_upd_val | output | XLEN | Base-update value |
| el_src | output | IW | Source (base) element number |
| el_dst | output | IW | Destination element number |
| el_upd | output | IW | Update register element number |

## Verification
A command whose `start` is sampled at edge N makes `busy` high after N. Its first element, or its first skip, is visible in the cycle after N. The address is formed combinationally from the read data in that same cycle. Each accepted element or skip moves to the next element at the following edge. `done` shows in the cycle after the final accept or skip, and `busy` drops one edge later. The bench steps a behavioural model on each rising edge, using only the pins it drives itself. It compares valid, busy, done and every element field 1 ns after each falling edge, so every result is checked in the cycle it is due. `el_ready` is randomised to exercise stalls.

// File: rtl/vlsu_agen_pkg.sv
package vlsu_agen_pkg;

  typedef enum logic [2:0] {
    AM_UNIT    = 3'd0,
    AM_ELEM    = 3'd1,
    AM_SPLAT   = 3'd2,
    AM_VBASE   = 3'd3,
    AM_POSTINC = 3'd4,
    AM_RIDX    = 3'd5,
    AM_RELEM   = 3'd6
  } amode_e;

  typedef struct packed {
    logic       indexed;
    logic       base_vec;
    logic       idx_vec;
    logic       dst_vec;
    logic       upd_vec;
    logic       els;
    logic       post_inc;
    logic       sea;
    logic [1:0] op_size;
    logic [1:0] src_ew;
  } cmd_flags_t;

endpackage

// File: rtl/vlsu_agen_mode.sv
module vlsu_agen_mode
  import vlsu_agen_pkg::*;
(
  input  cmd_flags_t flags,
  input  logic       imm_nz,
  output amode_e     mode
);

  always_comb begin
    if (flags.indexed) begin
      if (flags.els && !flags.base_vec && !flags.idx_vec) mode = AM_RELEM;
      else                                                mode = AM_RIDX;
    end else if (flags.post_inc) begin
      mode = AM_POSTINC;
    end else if (flags.base_vec) begin
      mode = AM_VBASE;
    end else if (!flags.els) begin
      mode = AM_UNIT;
    end else if (imm_nz) begin
      mode = AM_ELEM;
    end else begin
      mode = AM_SPLAT;
    end
  end

endmodule

// File: rtl/vlsu_agen_idxext.sv
module vlsu_agen_idxext #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      ew,
  input  logic            sea,
  output logic [XLEN-1:0] ext
);

  always_comb begin
    case (ew)
      2'd0:    ext = {{(XLEN-8){sea & raw[7]}},   raw[7:0]};
      2'd1:    ext = {{(XLEN-16){sea & raw[15]}}, raw[15:0]};
      2'd2:    ext = {{(XLEN-32){sea & raw[31]}}, raw[31:0]};
      default: ext = raw;
    endcase
  end

endmodule

// File: rtl/vlsu_agen_seq.sv
module vlsu_agen_seq #(
  parameter int MAXVL = 16,
  parameter int VLW   = $clog2(MAXVL + 1),
  parameter int IW    = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [MAXVL-1:0] pred,
  input  logic             any_vec,
  input  logic             dst_vec,
  input  logic             ready,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             valid,
  output logic [VLW-1:0]   elem
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

  logic             busy_q;
  logic [VLW-1:0]   e_q;
  logic [VLW-1:0]   vl_q;
  logic [MAXVL-1:0] pred_q;
  logic             anyv_q;
  logic             dstv_q;
  logic             at_end;
  logic             skip;
  logic             fire;

  assign accept = start && !busy_q;
  assign at_end = (e_q >= vl_q);
  assign skip   = !at_end && anyv_q && !pred_q[e_q[IW-1:0]];
  assign valid  = busy_q && !at_end && !skip;
  assign done   = busy_q && at_end;
  assign fire   = valid && ready;
  assign busy   = busy_q;
  assign elem   = e_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      e_q    <= '0;
      vl_q   <= '0;
      pred_q <= '0;
      anyv_q <= 1'b0;
      dstv_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      e_q    <= '0;
      vl_q   <= (vl > VL_CAP) ? VL_CAP : vl;
      pred_q <= pred;
      anyv_q <= any_vec;
      dstv_q <= dst_vec;
    end else if (busy_q) begin
      if (at_end)     busy_q <= 1'b0;
      else if (skip)  e_q    <= e_q + 1'b1;
      else if (fire)  e_q    <= dstv_q ? e_q + 1'b1 : vl_q;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(e_q)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q && !done); // R13

  AST_SCALAR_DST_END: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !dstv_q |=> done); // R12

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy_q && !done |=> $stable(vl_q) && $stable(pred_q)); // R2

endmodule

// File: rtl/vlsu_agen.sv
module vlsu_agen
  import vlsu_agen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MAXVL = 16,
  parameter int VLW   = $clog2(MAXVL + 1),
  parameter int IW    = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_indexed,
  input  logic             cfg_base_vec,
  input  logic             cfg_idx_vec,
  input  logic             cfg_dst_vec,
  input  logic             cfg_upd_vec,
  input  logic             cfg_els,
  input  logic             cfg_post_inc,
  input  logic             cfg_sea,
  input  logic [1:0]       cfg_op_size,
  input  logic [1:0]       cfg_src_ew,
  input  logic [XLEN-1:0]  cfg_imm,
  input  logic [VLW-1:0]   cfg_vl,
  input  logic [MAXVL-1:0] cfg_pred,
  output logic             busy,
  output logic             done,
  output logic [IW-1:0]    base_sel,
  input  logic [XLEN-1:0]  base_data,
  output logic [IW-1:0]    idx_sel,
  input  logic [XLEN-1:0]  idx_data,
  output logic             el_valid,
  input  logic             el_ready,
  output logic [XLEN-1:0]  el_addr,
  output logic [XLEN-1:0]  el_upd_val,
  output logic [IW-1:0]    el_src,
  output logic [IW-1:0]    el_dst,
  output logic [IW-1:0]    el_upd
);

  cmd_flags_t      flags_in;
  cmd_flags_t      flags_q;
  logic [XLEN-1:0] imm_q;
  logic            accept;
  logic [VLW-1:0]  elem;
  logic [IW-1:0]   e_idx;
  logic            any_vec_in;
  amode_e          mode;
  logic [XLEN-1:0] idx_x;
  logic [XLEN-1:0] mul_a;
  logic [XLEN-1:0] mul_b;
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] unit_off;

  assign flags_in = '{indexed:  cfg_indexed,  base_vec: cfg_base_vec,
                      idx_vec:  cfg_idx_vec,  dst_vec:  cfg_dst_vec,
                      upd_vec:  cfg_upd_vec,  els:      cfg_els,
                      post_inc: cfg_post_inc, sea:      cfg_sea,
                      op_size:  cfg_op_size,  src_ew:   cfg_src_ew};

  assign any_vec_in = cfg_base_vec | cfg_dst_vec | cfg_upd_vec |
                      (cfg_indexed & cfg_idx_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      imm_q   <= '0;
    end else if (accept) begin
      flags_q <= flags_in;
      imm_q   <= cfg_imm;
    end
  end

  vlsu_agen_seq #(.MAXVL(MAXVL), .VLW(VLW), .IW(IW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl      (cfg_vl),
    .pred    (cfg_pred),
    .any_vec (any_vec_in),
    .dst_vec (cfg_dst_vec),
    .ready   (el_ready),
    .accept  (accept),
    .busy    (busy),
    .done    (done),
    .valid   (el_valid),
    .elem    (elem)
  );

  vlsu_agen_mode u_mode (
    .flags  (flags_q),
    .imm_nz (|imm_q),
    .mode   (mode)
  );

  vlsu_agen_idxext #(.XLEN(XLEN)) u_idxext (
    .raw (idx_data),
    .ew  (flags_q.src_ew),
    .sea (flags_q.sea),
    .ext (idx_x)
  );

  assign e_idx    = elem[IW-1:0];
  assign base_sel = flags_q.base_vec ? e_idx : '0;
  assign idx_sel  = flags_q.idx_vec  ? e_idx : '0;
  assign el_src   = base_sel;
  assign el_dst   = flags_q.dst_vec  ? e_idx : '0;
  assign el_upd   = flags_q.upd_vec  ? e_idx : '0;

  // one multiplier shared by the two strided modes
  assign mul_a    = (mode == AM_RELEM) ? idx_x : imm_q;
  assign mul_b    = (mode == AM_RELEM) ? XLEN'(el_dst) : XLEN'(elem);
  assign prod     = mul_a * mul_b;
  assign unit_off = XLEN'(elem) << flags_q.op_size;

  always_comb begin
    el_upd_val = '0;
    case (mode)
      AM_UNIT:    el_addr = base_data + imm_q + unit_off;
      AM_ELEM:    el_addr = base_data + prod;
      AM_RIDX:    el_addr = base_data + idx_x;
      AM_RELEM:   el_addr = base_data + prod;
      AM_POSTINC: el_addr = base_data;
      default:    el_addr = base_data + imm_q;
    endcase
    if (mode == AM_POSTINC) el_upd_val = base_data + imm_q;
    else                    el_upd_val = el_addr;
  end

  AST_POSTINC_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && mode == AM_POSTINC |-> el_upd_val == el_addr + imm_q); // R7

  AST_INDEX_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && flags_q.indexed && !flags_q.sea && flags_q.src_ew == 2'd0
    |-> idx_x[XLEN-1:8] == '0); // R10

  AST_SCALAR_BASE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !flags_q.base_vec |-> el_src == '0); // R11

endmodule

// File: tb/vlsu_agen_tb.sv
module vlsu_agen_tb;

  localparam int XLEN  = 64;
  localparam int MAXVL = 16;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int IW    = $clog2(MAXVL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic             cfg_indexed = 0, cfg_base_vec = 0, cfg_idx_vec = 0;
  logic             cfg_dst_vec = 0, cfg_upd_vec = 0, cfg_els = 0;
  logic             cfg_post_inc = 0, cfg_sea = 0;
  logic [1:0]       cfg_op_size = 0, cfg_src_ew = 0;
  logic [XLEN-1:0]  cfg_imm = 0;
  logic [VLW-1:0]   cfg_vl = 0;
  logic [MAXVL-1:0] cfg_pred = 0;
  logic             busy, done, el_valid;
  logic             el_ready = 1'b0;
  logic [IW-1:0]    base_sel, idx_sel, el_src, el_dst, el_upd;
  logic [XLEN-1:0]  base_data, idx_data, el_addr, el_upd_val;

  logic [XLEN-1:0] rfb [MAXVL];
  logic [XLEN-1:0] rfi [MAXVL];
  assign base_data = rfb[base_sel];
  assign idx_data  = rfi[idx_sel];

  vlsu_agen #(.XLEN(XLEN), .MAXVL(MAXVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_indexed(cfg_indexed), .cfg_base_vec(cfg_base_vec),
    .cfg_idx_vec(cfg_idx_vec), .cfg_dst_vec(cfg_dst_vec),
    .cfg_upd_vec(cfg_upd_vec), .cfg_els(cfg_els),
    .cfg_post_inc(cfg_post_inc), .cfg_sea(cfg_sea),
    .cfg_op_size(cfg_op_size), .cfg_src_ew(cfg_src_ew),
    .cfg_imm(cfg_imm), .cfg_vl(cfg_vl), .cfg_pred(cfg_pred),
    .busy(busy), .done(done),
    .base_sel(base_sel), .base_data(base_data),
    .idx_sel(idx_sel), .idx_data(idx_data),
    .el_valid(el_valid), .el_ready(el_ready),
    .el_addr(el_addr), .el_upd_val(el_upd_val),
    .el_src(el_src), .el_dst(el_dst), .el_upd(el_upd)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_tag = "R1";
  bit random_ready = 1'b0;

  // model state
  int m_busy = 0, m_e = 0, m_vl = 0;
  logic m_ix, m_bv, m_iv, m_dv, m_uv, m_els, m_pi, m_sea;
  logic [1:0] m_sz, m_ew;
  logic [XLEN-1:0] m_imm;
  logic [MAXVL-1:0] m_pred;

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_skip(input int e);
    logic anyv;
    anyv = m_bv | m_dv | m_uv | (m_ix & m_iv);
    return anyv && !m_pred[e];
  endfunction

  function automatic logic [XLEN-1:0] xext(input logic [XLEN-1:0] v);
    case (m_ew)
      2'd0: return m_sea ? XLEN'($signed(v[7:0]))  : XLEN'(v[7:0]);
      2'd1: return m_sea ? XLEN'($signed(v[15:0])) : XLEN'(v[15:0]);
      2'd2: return m_sea ? XLEN'($signed(v[31:0])) : XLEN'(v[31:0]);
      default: return v;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_addr(input int e);
    logic [XLEN-1:0] b, x, ev, jv;
    b  = m_bv ? rfb[e] : rfb[0];
    x  = xext(m_iv ? rfi[e] : rfi[0]);
    ev = XLEN'(e);
    jv = m_dv ? ev : '0;
    if (m_ix) begin
      if (m_els && !m_bv && !m_iv) return b + x * jv;   // R9
      return b + x;                                     // R8
    end
    if (m_pi)     return b;                             // R7
    if (m_bv)     return b + m_imm;                     // R6
    if (!m_els)   return b + m_imm + ev * (64'd1 << m_sz); // R3
    if (m_imm != 0) return b + ev * m_imm;              // R4
    return b + m_imm;                                   // R5
  endfunction

  function automatic logic [XLEN-1:0] exp_upd(input int e);
    logic [XLEN-1:0] b;
    b = m_bv ? rfb[e] : rfb[0];
    if (!m_ix && m_pi) return b + m_imm;
    return exp_addr(e);
  endfunction

  // reference model, stepped on bench-driven pins only
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_e = 0;
    end else if (start && m_busy == 0) begin
      m_ix = cfg_indexed; m_bv = cfg_base_vec; m_iv = cfg_idx_vec;
      m_dv = cfg_dst_vec; m_uv = cfg_upd_vec; m_els = cfg_els;
      m_pi = cfg_post_inc; m_sea = cfg_sea; m_sz = cfg_op_size;
      m_ew = cfg_src_ew; m_imm = cfg_imm; m_pred = cfg_pred;
      m_vl = (int'(cfg_vl) > MAXVL) ? MAXVL : int'(cfg_vl);
      m_busy = 1; m_e = 0;
    end else if (m_busy != 0) begin
      if (m_e >= m_vl)      m_busy = 0;
      else if (m_skip(m_e)) m_e++;
      else if (el_ready)    m_e = m_dv ? m_e + 1 : m_vl;
    end
  end

  // compare every cycle, away from the rising edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      logic ev_exp;
      ev_exp = (m_busy != 0) && (m_e < m_vl) && !m_skip(m_e);
      chk("R2",  "busy",  XLEN'(busy), XLEN'(m_busy != 0));
      chk("R13", "done",  XLEN'(done), XLEN'((m_busy != 0) && (m_e >= m_vl)));
      chk("R11", "valid", XLEN'(el_valid), XLEN'(ev_exp));
      if (ev_exp) begin
        chk(cur_tag, "addr", el_addr, exp_addr(m_e));
        chk("R7",  "upd_val", el_upd_val, exp_upd(m_e));
        chk("R11", "src", XLEN'(el_src), m_bv ? XLEN'(m_e) : '0);
        chk("R11", "dst", XLEN'(el_dst), m_dv ? XLEN'(m_e) : '0);
        chk("R11", "upd", XLEN'(el_upd), m_uv ? XLEN'(m_e) : '0);
      end
    end
  end

  always begin
    @(negedge clk);
    el_ready <= random_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic issue(input string tag, input logic ix, bv, iv, dv, uv, els, pi, sea,
                       input logic [1:0] sz, ew, input logic [XLEN-1:0] imm,
                       input int vl, input logic [MAXVL-1:0] pred,
                       input bit restart_mid);
    @(negedge clk);
    cur_tag = tag;
    cfg_indexed = ix; cfg_base_vec = bv; cfg_idx_vec = iv; cfg_dst_vec = dv;
    cfg_upd_vec = uv; cfg_els = els; cfg_post_inc = pi; cfg_sea = sea;
    cfg_op_size = sz; cfg_src_ew = ew; cfg_imm = imm;
    cfg_vl = VLW'(vl); cfg_pred = pred;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_mid) begin
      // R2: a second start while busy with other settings must be ignored
      @(negedge clk);
      cfg_imm = 64'h5555; cfg_vl = 3; cfg_pred = '1; cfg_base_vec = ~bv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy != 0) begin
      @(negedge clk);
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog %s actual=hung expected=done", tag);
        finish_run();
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MAXVL; i++) begin
      rfb[i] = 64'h0000_4000_0000_0000 + 64'(i) * 64'h1_0010;
      rfi[i] = 64'hA5C3_0000_0000_0000 + 64'(i) * 64'h0131_9F83;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy",  XLEN'(busy), '0);
    chk("R1", "valid", XLEN'(el_valid), '0);
    chk("R1", "done",  XLEN'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // unit stride at each access size
    issue("R3", 0,0,0,1,0, 0,0,0, 2'd3, 2'd0, 64'h20, 5, '1, 0);
    issue("R3", 0,0,0,1,0, 0,0,0, 2'd0, 2'd0, 64'h3,  4, '1, 0);
    random_ready = 1'b1;
    issue("R3", 0,0,0,1,0, 0,0,0, 2'd1, 2'd0, 64'h0,  6, '1, 0);
    issue("R3", 0,0,0,1,1, 0,0,0, 2'd2, 2'd0, 64'h8,  7, 16'hFFFF, 0);
    // element stride, negative step
    issue("R4", 0,0,0,1,0, 1,0,0, 2'd3, 2'd0, -64'sd24, 8, '1, 0);
    // splat with zero immediate
    issue("R5", 0,0,0,1,0, 1,0,0, 2'd3, 2'd0, 64'h0, 6, '1, 0);
    // vector base plus immediate, predicate holes, els ignored
    issue("R6", 0,1,0,1,1, 1,0,0, 2'd2, 2'd0, 64'h40, 9, 16'b1_0110_1101, 0);
    // post-increment with vector base
    issue("R7", 0,1,0,1,1, 0,1,0, 2'd3, 2'd0, 64'h18, 5, 16'b1_1011, 0);
    // register indexed, signed 8-bit and unsigned 16-bit index
    issue("R8", 1,1,1,1,0, 0,0,1, 2'd3, 2'd0, 64'h0, 10, 16'h03F7, 0);
    issue("R10", 1,0,1,1,0, 0,0,0, 2'd3, 2'd1, 64'h0, 6, '1, 0);
    issue("R10", 1,1,1,1,0, 0,0,1, 2'd3, 2'd2, 64'h0, 6, '1, 0);
    // register element stride with scalar operands, sign-extended 32-bit
    rfi[0] = 64'h0000_0000_FFFF_FFF8;
    issue("R9", 1,0,0,1,0, 1,0,1, 2'd3, 2'd2, 64'h0, 7, '1, 0);
    // scalar destination: one element, first active only
    issue("R12", 0,1,0,0,0, 0,0,0, 2'd3, 2'd0, 64'h10, 8, 16'b1100, 0);
    // VL=0 and VL above the maximum
    issue("R13", 0,0,0,1,0, 0,0,0, 2'd3, 2'd0, 64'h0, 0, '1, 0);
    issue("R13", 0,0,0,1,0, 0,0,0, 2'd0, 2'd0, 64'h1, 20, '1, 0);
    // all predicate bits off with vector operands
    issue("R11", 0,1,0,1,0, 0,0,0, 2'd3, 2'd0, 64'h0, 5, '0, 0);
    // start while busy is ignored
    issue("R2", 0,0,0,1,0, 0,0,0, 2'd2, 2'd0, 64'h100, 8, '1, 1);
    // wrap around the top of the address space
    rfb[0] = 64'hFFFF_FFFF_FFFF_FFF0;
    issue("R14", 0,0,0,1,0, 0,0,0, 2'd3, 2'd0, 64'h8, 4, '1, 0);
    issue("R14", 0,0,0,1,0, 0,1,0, 2'd3, 2'd0, 64'h20, 3, '1, 0);

    finish_run();
  end

endmodule